// File: doc/BRIEF.md
# Counted-Pin Interrupt Delivery Core

This core turns per-pin interrupt activity into interrupt messages for a bank of 32 input pins. A pin has no wire level. Each pin keeps a saturating 8-bit count of raise and drop events. Raise, drop and pulse commands arrive on a valid/ready command port. Each accepted command gets a one-cycle response that carries a result code. A message is considered only when a pin's count leaves zero. The redirection entry of that pin then decides the outcome. The entry can mask the pin, can make it level-triggered and so gate it by a remote-IRR bit, and supplies the vector, destination, destination mode and delivery mode of the message.

A register front end writes whole 64-bit redirection entries through a write port. A write to a level-triggered pin whose count is above zero also acts as a delivery request. Any entry and count can be read back at any time. An end-of-interrupt broadcast names a vector. The core then walks every pin once, one pin per clock, in ascending order. It clears remote-IRR on each pin that matches the vector and sends the message again for any matching pin that is still raised. Messages leave on one valid/ready port. Saturation events and sent messages are counted on plain statistic outputs.

Top module: `irq_delivery_core`

## Requirements
- R1: A raise command (op code 0) adds one to the pin count. If the count is already 255, the command instead returns code 1 (overflow), leaves the count at 255 and adds one to `stat_sat_hi`. Every accepted command gets `rsp_valid` high with its code on the cycle after acceptance. Code 0 means success.
- R2: A drop command (op code 1) subtracts one from the pin count. If the count is zero, the command instead returns code 2 (underflow), leaves the count at zero and adds one to `stat_sat_lo`.
- R3: A delivery attempt happens only when a raise takes the count from 0 to 1. A raise from a count above zero gives no message. A drop, including one from 1 to 0, gives no message.
- R4: A pulse command (op code 2) acts as a raise followed by a drop, so the count ends where it started. A pulse on a zero count makes one delivery attempt. A pulse on a count of 255 returns overflow, adds one to `stat_sat_hi` and skips the drop.
- R5: A command whose pin index is 32 or higher, or whose op code is 3, returns code 3 (invalid). It changes no count, no entry and no statistic.
- R6: After reset, every entry reads 64'h0000_0000_0001_0000 (mask bit 16 set), every count reads 0, all statistics read 0 and no message is pending. A delivery attempt on a pin with bit 16 set sends nothing.
- R7: On a level-triggered pin (bit 15 = 1), a delivery attempt while remote-IRR (bit 14) is set sends nothing. Otherwise the attempt sends a message and sets bit 14. On an edge-triggered pin, bit 14 is never set.
- R8: A message carries the vector from entry bits 7:0, the destination from bits 63:56, the logical-mode flag from bit 11 (1 = logical), the delivery mode from bits 10:8, and the level flag equal to bit 15. `stat_irq` counts every message sent.
- R9: An entry write keeps the stored bits 14 and 12, whatever the write data holds there. A write with bit 15 = 0 clears bit 14. After the write, a level-triggered pin with a count above zero makes a delivery attempt.
- R10: An end-of-interrupt for vector v clears bit 14 on every pin that has bit 14 set and bits 7:0 equal to v. Any such pin whose count is above zero is delivered again. The resulting messages leave in ascending pin order. Pins with another vector are left unchanged.
- R11: An accepted end-of-interrupt holds `busy` high for exactly 32 cycles when messages drain freely. While `busy` is high, `cmd_ready`, `rte_wr_ready` and `eoi_ready` are low. An end-of-interrupt is accepted only while no command and no entry write is offered.
- R12: A message transfers on a cycle where `msg_valid` and `msg_ready` are both high. While `msg_ready` is low, the message fields hold steady, and no command, entry write or walk step that could produce a message proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Pin command offered |
| cmd_ready | output | 1 | Pin command accepted this cycle when valid |
| cmd_op | input | 2 | 0 raise, 1 drop, 2 pulse, 3 invalid |
| cmd_pin | input | 6 | Target pin index (values of 32 and up are invalid) |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_code | output | 2 | 0 ok, 1 overflow, 2 underflow, 3 invalid |
| rte_wr_valid | input | 1 | Entry write offered |
| rte_wr_ready | output | 1 | Entry write accepted this cycle when valid |
| rte_wr_pin | input | 5 | Entry index to write |
| rte_wr_data | input | 64 | New entry contents |
| eoi_valid | input | 1 | End-of-interrupt offered |
| eoi_ready | output | 1 | End-of-interrupt accepted this cycle when valid |
| eoi_vector | input | 8 | Vector being retired |
| busy | output | 1 | End-of-interrupt walk in progress |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_logical | output | 1 | 1 for logical destination mode |
| msg_delmode | output | 3 | Delivery mode |
| msg_level | output | 1 | 1 when the source pin is level-triggered |
| rd_pin | input | 5 | Read-back index |
| rd_entry | output | 64 | Entry at `rd_pin` |
| rd_count | output | 8 | Count at `rd_pin` |
| stat_irq | output | 32 | Messages sent |
| stat_sat_hi | output | 32 | Overflow events |
| stat_sat_lo | output | 32 | Underflow events |

## Verification
The assertions assume that every field offered with a valid strobe is a known value. They also assume that entry writes only name existing pins, since `rte_wr_pin` carries no range check. The stimulus drives every field on the falling clock edge and holds it until acceptance. It only writes entries for pins below 32, and it sends out-of-range pins and op code 3 only through the command port, where they must be rejected. The consumer ready line is held high except during one deliberate back-pressure window, so the 32-cycle walk length can be checked exactly.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ENTRY_W = 64;
    localparam int VEC_W   = 8;

    typedef enum logic [1:0] {
        PIN_RAISE = 2'd0,
        PIN_DROP  = 2'd1,
        PIN_PULSE = 2'd2
    } pin_op_e;

    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_OVERFLOW  = 2'd1,
        RES_UNDERFLOW = 2'd2,
        RES_INVALID   = 2'd3
    } pin_res_e;

    // Redirection entry; bit positions are decoded by the register front end.
    typedef struct packed {
        logic [7:0]       dest;        // 63:56
        logic [38:0]      spare;       // 55:17
        logic             masked;      // 16
        logic             level_trig;  // 15
        logic             rirr;        // 14 (read-only)
        logic             polarity;    // 13
        logic             in_flight;   // 12 (read-only)
        logic             logical;     // 11
        logic [2:0]       delmode;     // 10:8
        logic [VEC_W-1:0] vector;      // 7:0
    } entry_t;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic [7:0]       dest;
        logic             logical;
        logic [2:0]       delmode;
        logic             level;
    } imsg_t;

    typedef struct packed {
        logic   send;
        entry_t entry;
        imsg_t  msg;
    } attempt_t;

    localparam entry_t ENTRY_RESET = entry_t'(64'h0000_0000_0001_0000);

    // One delivery attempt against an entry: decides, builds the message,
    // and returns the entry with remote-IRR updated.
    function automatic attempt_t try_deliver(entry_t e);
        attempt_t a;
        a.entry       = e;
        a.send        = 1'b0;
        a.msg.vector  = e.vector;
        a.msg.dest    = e.dest;
        a.msg.logical = e.logical;
        a.msg.delmode = e.delmode;
        a.msg.level   = e.level_trig;
        if (!e.masked && !(e.level_trig && e.rirr)) begin
            a.send = 1'b1;
            if (e.level_trig) begin
                a.entry.rirr = 1'b1;
            end
        end
        return a;
    endfunction

    // Merge a front-end write with the stored entry: read-only bits survive,
    // switching to edge trigger drops remote-IRR.
    function automatic entry_t merge_write(entry_t old, entry_t wr);
        entry_t r;
        r           = wr;
        r.rirr      = old.rirr;
        r.in_flight = old.in_flight;
        if (!r.level_trig) begin
            r.rirr = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/irqd_pin_bank.sv
module irqd_pin_bank
    import irqd_pkg::*;
#(
    parameter int  NPINS = 32,
    parameter int  CNT_W = 8,
    localparam int IDX_W = $clog2(NPINS),
    localparam int PIN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [PIN_W-1:0] upd_pin,
    input  pin_op_e          upd_op,
    output pin_res_e         eval_res,
    output logic             eval_rise,
    output logic [CNT_W-1:0] cnt_o [NPINS]
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [NPINS];
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] nxt;

    assign in_range = upd_pin < PIN_W'(NPINS);
    assign idx      = upd_pin[IDX_W-1:0];
    assign cur      = in_range ? cnt_q[idx] : '0;

    always_comb begin
        nxt       = cur;
        eval_res  = RES_OK;
        eval_rise = 1'b0;
        if (!in_range) begin
            eval_res = RES_INVALID;
        end else begin
            unique case (upd_op)
                PIN_RAISE: begin
                    if (cur == CNT_MAX) begin
                        eval_res = RES_OVERFLOW;
                    end else begin
                        nxt       = cur + 1'b1;
                        eval_rise = (cur == '0);
                    end
                end
                PIN_DROP: begin
                    if (cur == '0) begin
                        eval_res = RES_UNDERFLOW;
                    end else begin
                        nxt = cur - 1'b1;
                    end
                end
                PIN_PULSE: begin
                    // raise then drop: net count unchanged, drop skipped on overflow
                    if (cur == CNT_MAX) begin
                        eval_res = RES_OVERFLOW;
                    end else begin
                        eval_rise = (cur == '0);
                    end
                end
                default: eval_res = RES_INVALID;
            endcase
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '0;
            end else if (upd_en && eval_res == RES_OK && idx == IDX_W'(g)) begin
                cnt_q[g] <= nxt;
            end
        end
    end

    assign cnt_o = cnt_q;

    p_raise_inc_r1: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_op == PIN_RAISE && eval_res == RES_OK
        |=> cnt_q[$past(idx)] == $past(cur) + 1'b1);

    p_ovf_hold_r1: assert property (@(posedge clk) disable iff (rst)
        upd_en && eval_res == RES_OVERFLOW |=> cnt_q[$past(idx)] == CNT_MAX);

    p_drop_dec_r2: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_op == PIN_DROP && eval_res == RES_OK
        |=> cnt_q[$past(idx)] == $past(cur) - 1'b1);

    p_rise_target_r3: assert property (@(posedge clk) disable iff (rst)
        upd_en && eval_rise
        |=> cnt_q[$past(idx)] == (($past(upd_op) == PIN_RAISE) ? CNT_W'(1) : CNT_W'(0)));

endmodule

// File: rtl/irqd_entry_store.sv
module irqd_entry_store
    import irqd_pkg::*;
#(
    parameter int  NPINS = 32,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  entry_t           upd_val,
    output entry_t           entry_o [NPINS]
);

    entry_t entry_q [NPINS];

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= ENTRY_RESET;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                entry_q[g] <= upd_val;
            end
        end

        p_edge_no_rirr_r7: assert property (@(posedge clk) disable iff (rst)
            entry_q[g].rirr |-> entry_q[g].level_trig);
    end

    assign entry_o = entry_q;

endmodule

// File: rtl/irqd_msg_slot.sv
module irqd_msg_slot
    import irqd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  imsg_t load_msg,
    output logic  out_valid,
    input  logic  out_ready,
    output imsg_t out_msg,
    output logic  free
);

    logic  valid_q;
    imsg_t msg_q;

    assign free      = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_msg   = msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            msg_q   <= load_msg;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        valid_q && !out_ready |=> valid_q && $stable(msg_q));

    p_load_room_r12: assert property (@(posedge clk) disable iff (rst)
        load |-> (!valid_q || out_ready));

endmodule

// File: rtl/irq_delivery_core.sv
module irq_delivery_core
    import irqd_pkg::*;
#(
    parameter int  NPINS  = 32,
    parameter int  CNT_W  = 8,
    parameter int  STAT_W = 32,
    localparam int IDX_W  = $clog2(NPINS),
    localparam int PIN_W  = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [PIN_W-1:0]    cmd_pin,
    output logic                rsp_valid,
    output logic [1:0]          rsp_code,
    input  logic                rte_wr_valid,
    output logic                rte_wr_ready,
    input  logic [IDX_W-1:0]    rte_wr_pin,
    input  logic [ENTRY_W-1:0]  rte_wr_data,
    input  logic                eoi_valid,
    output logic                eoi_ready,
    input  logic [VEC_W-1:0]    eoi_vector,
    output logic                busy,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [VEC_W-1:0]    msg_vector,
    output logic [7:0]          msg_dest,
    output logic                msg_logical,
    output logic [2:0]          msg_delmode,
    output logic                msg_level,
    input  logic [IDX_W-1:0]    rd_pin,
    output logic [ENTRY_W-1:0]  rd_entry,
    output logic [CNT_W-1:0]    rd_count,
    output logic [STAT_W-1:0]   stat_irq,
    output logic [STAT_W-1:0]   stat_sat_hi,
    output logic [STAT_W-1:0]   stat_sat_lo
);

    entry_t           entry_arr [NPINS];
    logic [CNT_W-1:0] cnt_arr   [NPINS];

    logic             walking;
    logic [IDX_W-1:0] walk_idx;
    logic [VEC_W-1:0] walk_vec;

    logic             slot_free;
    logic             cmd_fire;
    logic             wr_fire;
    logic             eoi_fire;
    logic [IDX_W-1:0] cmd_idx;
    pin_res_e         eval_res;
    logic             eval_rise;

    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    entry_t           upd_val;
    logic             load;
    imsg_t            load_msg;
    imsg_t            out_msg;

    pin_res_e         rsp_code_q;
    logic             rsp_valid_q;
    logic [STAT_W-1:0] irq_q;
    logic [STAT_W-1:0] hi_q;
    logic [STAT_W-1:0] lo_q;

    // Acceptance: walk first, then commands, then entry writes, then EOI.
    assign cmd_ready    = !walking && slot_free;
    assign rte_wr_ready = !walking && slot_free && !cmd_valid;
    assign eoi_ready    = !walking && !cmd_valid && !rte_wr_valid;
    assign cmd_fire     = cmd_valid && cmd_ready;
    assign wr_fire      = rte_wr_valid && rte_wr_ready;
    assign eoi_fire     = eoi_valid && eoi_ready;
    assign cmd_idx      = cmd_pin[IDX_W-1:0];
    assign busy         = walking;

    irqd_pin_bank #(.NPINS(NPINS), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (cmd_fire),
        .upd_pin  (cmd_pin),
        .upd_op   (pin_op_e'(cmd_op)),
        .eval_res (eval_res),
        .eval_rise(eval_rise),
        .cnt_o    (cnt_arr)
    );

    irqd_entry_store #(.NPINS(NPINS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .upd_idx(upd_idx),
        .upd_val(upd_val),
        .entry_o(entry_arr)
    );

    irqd_msg_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_msg (load_msg),
        .out_valid(msg_valid),
        .out_ready(msg_ready),
        .out_msg  (out_msg),
        .free     (slot_free)
    );

    always_comb begin : p_main
        attempt_t att;
        entry_t   e;
        upd_en   = 1'b0;
        upd_idx  = '0;
        upd_val  = ENTRY_RESET;
        load     = 1'b0;
        load_msg = '0;
        att      = '0;
        e        = ENTRY_RESET;
        if (walking) begin
            if (slot_free) begin
                e = entry_arr[walk_idx];
                if (e.rirr && e.vector == walk_vec) begin
                    e.rirr = 1'b0;
                    if (cnt_arr[walk_idx] != '0) begin
                        att      = try_deliver(e);
                        e        = att.entry;
                        load     = att.send;
                        load_msg = att.msg;
                    end
                    upd_en  = 1'b1;
                    upd_idx = walk_idx;
                    upd_val = e;
                end
            end
        end else if (cmd_fire) begin
            if (eval_rise) begin
                att      = try_deliver(entry_arr[cmd_idx]);
                load     = att.send;
                load_msg = att.msg;
                upd_en   = att.send;
                upd_idx  = cmd_idx;
                upd_val  = att.entry;
            end
        end else if (wr_fire) begin
            e = merge_write(entry_arr[rte_wr_pin], entry_t'(rte_wr_data));
            if (e.level_trig && cnt_arr[rte_wr_pin] != '0) begin
                att      = try_deliver(e);
                e        = att.entry;
                load     = att.send;
                load_msg = att.msg;
            end
            upd_en  = 1'b1;
            upd_idx = rte_wr_pin;
            upd_val = e;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            walking     <= 1'b0;
            walk_idx    <= '0;
            walk_vec    <= '0;
            rsp_valid_q <= 1'b0;
            rsp_code_q  <= RES_OK;
            irq_q       <= '0;
            hi_q        <= '0;
            lo_q        <= '0;
        end else begin
            if (eoi_fire) begin
                walking  <= 1'b1;
                walk_idx <= '0;
                walk_vec <= eoi_vector;
            end else if (walking && slot_free) begin
                walk_idx <= walk_idx + 1'b1;
                if (walk_idx == IDX_W'(NPINS - 1)) begin
                    walking <= 1'b0;
                end
            end
            rsp_valid_q <= cmd_fire;
            rsp_code_q  <= cmd_fire ? eval_res : RES_OK;
            if (load) begin
                irq_q <= irq_q + 1'b1;
            end
            if (cmd_fire && eval_res == RES_OVERFLOW) begin
                hi_q <= hi_q + 1'b1;
            end
            if (cmd_fire && eval_res == RES_UNDERFLOW) begin
                lo_q <= lo_q + 1'b1;
            end
        end
    end

    assign rsp_valid   = rsp_valid_q;
    assign rsp_code    = rsp_code_q;
    assign msg_vector  = out_msg.vector;
    assign msg_dest    = out_msg.dest;
    assign msg_logical = out_msg.logical;
    assign msg_delmode = out_msg.delmode;
    assign msg_level   = out_msg.level;
    assign rd_entry    = entry_arr[rd_pin];
    assign rd_count    = cnt_arr[rd_pin];
    assign stat_irq    = irq_q;
    assign stat_sat_hi = hi_q;
    assign stat_sat_lo = lo_q;

    p_rsp_next_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> rsp_valid);

    p_invalid_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_fire && eval_res == RES_INVALID |-> !load && !upd_en);

    p_masked_silent_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_fire && entry_arr[cmd_idx].masked |-> !load);

    p_rirr_gate_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_fire && entry_arr[cmd_idx].level_trig && entry_arr[cmd_idx].rirr |-> !load);

    p_irq_count_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> stat_irq == $past(stat_irq) + 1'b1);

    p_walk_start_r11: assert property (@(posedge clk) disable iff (rst)
        eoi_fire |=> busy && walk_idx == '0);

    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready && !rte_wr_ready && !eoi_ready);

endmodule

// File: tb/irq_delivery_core_tb.sv
module irq_delivery_core_tb;

    localparam int NPINS  = 32;
    localparam int CNT_W  = 8;
    localparam int STAT_W = 32;
    localparam int IDX_W  = 5;
    localparam int PIN_W  = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic               cmd_valid, cmd_ready;
    logic [1:0]         cmd_op;
    logic [PIN_W-1:0]   cmd_pin;
    logic               rsp_valid;
    logic [1:0]         rsp_code;
    logic               rte_wr_valid, rte_wr_ready;
    logic [IDX_W-1:0]   rte_wr_pin;
    logic [63:0]        rte_wr_data;
    logic               eoi_valid, eoi_ready;
    logic [7:0]         eoi_vector;
    logic               busy;
    logic               msg_valid, msg_ready;
    logic [7:0]         msg_vector, msg_dest;
    logic               msg_logical;
    logic [2:0]         msg_delmode;
    logic               msg_level;
    logic [IDX_W-1:0]   rd_pin;
    logic [63:0]        rd_entry;
    logic [CNT_W-1:0]   rd_count;
    logic [STAT_W-1:0]  stat_irq, stat_sat_hi, stat_sat_lo;

    irq_delivery_core #(.NPINS(NPINS), .CNT_W(CNT_W), .STAT_W(STAT_W)) u_dut (.*);

    int total = 0;
    int fails = 0;
    int exp_msgs = 0;
    bit done = 1'b0;
    logic [20:0] expq [$];

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_msg(input logic [7:0] vec, input logic [7:0] dst,
                              input logic lg, input logic [2:0] dm, input logic lv);
        expq.push_back({vec, dst, lg, dm, lv});
        exp_msgs++;
    endtask

    // Monitor: samples late in the low phase, after all drives.
    always @(negedge clk) begin
        logic [20:0] got;
        logic [20:0] want;
        #3;
        if (!rst && msg_valid && msg_ready) begin
            got = {msg_vector, msg_dest, msg_logical, msg_delmode, msg_level};
            if (expq.size() == 0) begin
                check_eq("R3", "unexpected message", longint'(got), 0);
            end else begin
                want = expq.pop_front();
                check_eq("R8", "message fields", longint'(got), longint'(want));
            end
        end
    end

    task automatic do_cmd(input logic [1:0] op, input int pin, input logic [1:0] exp,
                          input string req, input bit chk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pin = PIN_W'(pin);
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        if (chk) begin
            check_eq(req, "response strobe", longint'(rsp_valid), 1);
            check_eq(req, "response code", longint'(rsp_code), longint'(exp));
        end
    endtask

    task automatic write_entry(input int pin, input logic [63:0] data);
        @(negedge clk);
        rte_wr_valid = 1'b1; rte_wr_pin = IDX_W'(pin); rte_wr_data = data;
        #1;
        while (!rte_wr_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        rte_wr_valid = 1'b0;
        #1;
    endtask

    task automatic do_eoi(input logic [7:0] vec, output int cycles, output bit leaked);
        cycles = 0; leaked = 1'b0;
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = vec;
        #1;
        while (!eoi_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        eoi_valid = 1'b0;
        #1;
        while (busy) begin
            if (cmd_ready || rte_wr_ready || eoi_ready) leaked = 1'b1;
            cycles++;
            @(negedge clk); #1;
        end
    endtask

    task automatic read_pin(input int pin, output logic [63:0] ent, output logic [CNT_W-1:0] cnt);
        rd_pin = IDX_W'(pin);
        #1;
        ent = rd_entry; cnt = rd_count;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] ent;
        logic [CNT_W-1:0] cnt;
        int cyc;
        bit leak;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_pin = '0;
        rte_wr_valid = 1'b0; rte_wr_pin = '0; rte_wr_data = '0;
        eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b1; rd_pin = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R6 reset state
        read_pin(0, ent, cnt);
        check_eq("R6", "reset entry", longint'(ent), 64'h0000_0000_0001_0000);
        check_eq("R6", "reset count", longint'(cnt), 0);
        check_eq("R6", "reset msg_valid", longint'(msg_valid), 0);
        check_eq("R6", "reset stats", longint'(stat_irq | stat_sat_hi | stat_sat_lo), 0);

        // R6 masked pin raises silently; R1/R2 counting
        do_cmd(2'd0, 3, 2'd0, "R1", 1'b1);
        read_pin(3, ent, cnt);
        check_eq("R1", "count after raise", longint'(cnt), 1);
        do_cmd(2'd1, 3, 2'd0, "R2", 1'b1);
        do_cmd(2'd1, 3, 2'd2, "R2", 1'b1);
        read_pin(3, ent, cnt);
        check_eq("R2", "count held at zero", longint'(cnt), 0);
        check_eq("R2", "sat low stat", longint'(stat_sat_lo), 1);

        // Edge pin 5: vector 41, logical, mode 1, dest A5
        write_entry(5, 64'hA500_0000_0000_0941);
        expect_msg(8'h41, 8'hA5, 1'b1, 3'd1, 1'b0);
        do_cmd(2'd0, 5, 2'd0, "R3", 1'b1);
        read_pin(5, ent, cnt);
        check_eq("R7", "edge pin remote-IRR", longint'(ent[14]), 0);
        do_cmd(2'd0, 5, 2'd0, "R3", 1'b1);   // 1->2: no message
        do_cmd(2'd1, 5, 2'd0, "R3", 1'b1);
        do_cmd(2'd1, 5, 2'd0, "R3", 1'b1);   // 1->0: no message
        expect_msg(8'h41, 8'hA5, 1'b1, 3'd1, 1'b0);
        do_cmd(2'd2, 5, 2'd0, "R4", 1'b1);   // pulse from zero
        read_pin(5, ent, cnt);
        check_eq("R4", "count after pulse", longint'(cnt), 0);

        // Level pin 7: vector 62, physical, dest 03
        write_entry(7, 64'h0300_0000_0000_8062);
        expect_msg(8'h62, 8'h03, 1'b0, 3'd0, 1'b1);
        do_cmd(2'd0, 7, 2'd0, "R7", 1'b1);
        read_pin(7, ent, cnt);
        check_eq("R7", "remote-IRR set", longint'(ent[14]), 1);
        do_cmd(2'd1, 7, 2'd0, "R7", 1'b1);
        do_cmd(2'd0, 7, 2'd0, "R7", 1'b1);   // gated by remote-IRR
        expect_msg(8'h62, 8'h03, 1'b0, 3'd0, 1'b1);
        do_eoi(8'h62, cyc, leak);            // R10 redelivery
        read_pin(7, ent, cnt);
        check_eq("R10", "remote-IRR after redelivery", longint'(ent[14]), 1);
        do_cmd(2'd1, 7, 2'd0, "R10", 1'b1);
        do_eoi(8'h62, cyc, leak);            // clears, count zero, no message
        read_pin(7, ent, cnt);
        check_eq("R10", "remote-IRR cleared", longint'(ent[14]), 0);
        expect_msg(8'h62, 8'h03, 1'b0, 3'd0, 1'b1);
        do_cmd(2'd0, 7, 2'd0, "R10", 1'b1);
        do_eoi(8'h63, cyc, leak);            // other vector: untouched
        read_pin(7, ent, cnt);
        check_eq("R10", "other vector leaves remote-IRR", longint'(ent[14]), 1);

        // R9 entry writes
        write_entry(7, 64'h0300_0000_0000_C062);   // still gated
        write_entry(7, 64'h0300_0000_0000_0062);   // to edge: clears
        read_pin(7, ent, cnt);
        check_eq("R9", "edge write clears remote-IRR", longint'(ent[14]), 0);
        expect_msg(8'h62, 8'h03, 1'b0, 3'd0, 1'b1);
        write_entry(7, 64'h0300_0000_0000_8062);   // level with count 1: delivers
        read_pin(7, ent, cnt);
        check_eq("R9", "level write delivery sets remote-IRR", longint'(ent[14]), 1);
        write_entry(9, 64'h0000_0000_0001_D000);
        read_pin(9, ent, cnt);
        check_eq("R9", "read-only bits 14 and 12 kept", longint'(ent), 64'h0000_0000_0001_8000);

        // R1/R4 saturation on masked pin 10
        for (int i = 0; i < 255; i++) do_cmd(2'd0, 10, 2'd0, "R1", 1'b0);
        read_pin(10, ent, cnt);
        check_eq("R1", "count at limit", longint'(cnt), 255);
        do_cmd(2'd0, 10, 2'd1, "R1", 1'b1);
        do_cmd(2'd2, 10, 2'd1, "R4", 1'b1);
        read_pin(10, ent, cnt);
        check_eq("R4", "count held at limit", longint'(cnt), 255);
        check_eq("R4", "sat high stat", longint'(stat_sat_hi), 2);

        // R5 invalid
        do_cmd(2'd0, 32, 2'd3, "R5", 1'b1);
        do_cmd(2'd3, 0, 2'd3, "R5", 1'b1);
        read_pin(0, ent, cnt);
        check_eq("R5", "count unchanged", longint'(cnt), 0);
        check_eq("R5", "stats unchanged", longint'(stat_sat_hi + stat_sat_lo), 3);

        // R10/R11 ordered walk
        write_entry(12, 64'h0C00_0000_0000_8070);
        write_entry(20, 64'h1400_0000_0000_8070);
        expect_msg(8'h70, 8'h0C, 1'b0, 3'd0, 1'b1);
        do_cmd(2'd0, 12, 2'd0, "R10", 1'b1);
        expect_msg(8'h70, 8'h14, 1'b0, 3'd0, 1'b1);
        do_cmd(2'd0, 20, 2'd0, "R10", 1'b1);
        expect_msg(8'h70, 8'h0C, 1'b0, 3'd0, 1'b1);
        expect_msg(8'h70, 8'h14, 1'b0, 3'd0, 1'b1);
        do_eoi(8'h70, cyc, leak);
        check_eq("R11", "busy cycles", longint'(cyc), 32);
        check_eq("R11", "ready while busy", longint'(leak), 0);

        // R12 back-pressure
        msg_ready = 1'b0;
        expect_msg(8'h41, 8'hA5, 1'b1, 3'd1, 1'b0);
        do_cmd(2'd0, 5, 2'd0, "R12", 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check_eq("R12", "held valid", longint'(msg_valid), 1);
            check_eq("R12", "held vector", longint'(msg_vector), 8'h41);
            check_eq("R12", "cmd_ready while blocked", longint'(cmd_ready), 0);
        end
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk); #1;
        check_eq("R12", "drained", longint'(msg_valid), 0);

        repeat (4) @(negedge clk);
        check_eq("R8", "message counter", longint'(stat_irq), longint'(exp_msgs));
        check_eq("R3", "pending expected messages", longint'(expq.size()), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule